// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block runs serial flash transactions from a small programmable table instead of hard-wired command flows. Software loads up to eight sequences through a word-wide register port. Each sequence is four 32-bit table words, and each word holds two 16-bit instructions. One write to the trigger register picks a sequence and, if wanted, a byte count. The engine then drives chip select, a serial clock and one data line in each direction. It walks the sequence one instruction at a time: it shifts out a command byte, shifts out an address, idles for dummy clocks, reads bytes into a receive buffer, or writes bytes taken from a transmit buffer.

The table is write-protected. A key word has to be written, and the very next register write has to be an unlock command, before table writes are accepted. The same pattern with a lock command protects the table again. A trigger that arrives while a sequence is running, and a table write while the table is locked, are both dropped and set a sticky error flag.

The engine is one state machine. It has six states. IDLE waits for a trigger, and a trigger moves it to SETUP. SETUP lowers chip select and moves to LOAD. LOAD fetches the instruction at the program counter. On an end marker it moves to HOLD. On an empty instruction it steps the counter and stays in LOAD. Otherwise it moves to LOW. LOW is the low clock phase and lasts `HALF_DIV` clocks, then moves to HIGH, sampling the input line. HIGH is the high clock phase. At its end it goes back to LOW for the next bit or byte, or to LOAD once the instruction is complete. HOLD keeps chip select low for one clock and then returns to IDLE.

Top module: `lutflash_seq`

## Requirements
- R1: After reset the status register (0x004) reads 0x00000008, which means locked and nothing else set. `flash_cs_n` is high and `flash_sclk` is low.
- R2: Status bit 3 shows that the table is locked, and the table starts locked after reset. Writes to the table window (0x200 + 4·word) are ignored while it is locked. Writing 0x5AF00FA5 to 0x014 and then, as the very next register write, 1 to 0x018 unlocks the table. The same pattern with 2 locks it. Any other write in between cancels the key.
- R3: Sequence s owns table words 4s to 4s+3. The instruction in bits 15:0 of a word runs before the one in bits 31:16. An instruction holds the opcode in bits 15:10, the pad in bits 9:8 (0 means single line) and the operand in bits 7:0. The opcodes are 0 stop, 1 command, 2 address, 3 dummy, 4 read and 5 write. Opcode 0, an unknown opcode, or running past the eighth instruction ends the sequence.
- R4: A command instruction shifts its operand out on `flash_mosi`, MSB first, in SPI mode 0. `flash_mosi` only changes while `flash_sclk` is low, and `flash_miso` is sampled on the rising edge.
- R5: An address instruction shifts out all 32 bits of the address register (0x008) when its operand is 32. For any other operand it shifts out the low 24 bits. Both are MSB first.
- R6: A dummy instruction produces as many clock cycles as its operand, with `flash_mosi` held low.
- R7: A read instruction stores the received bytes in arrival order. Word i of the receive buffer reads at 0x100 + 4i with byte 4i in bits 7:0. Status bits 15:8 give the stored byte count and bit 1 shows that data is present. The buffer holds 128 bytes, and a longer read is cut to 128 bytes.
- R8: A write instruction sends bytes from the transmit buffer in the order they were pushed. Each write to 0x010 pushes four bytes, bits 7:0 first. The buffer holds 64 bytes.
- R9: Writing 0x00C with the size in bits 7:0 and the sequence in bits 11:8 starts a sequence. A nonzero size replaces the byte count of the read or write instruction. Busy (status bit 0) and a low chip select begin on the next clock. Both end together, at least one clock after the last falling clock edge.
- R10: A trigger while busy is ignored. It and a locked table write set the sticky error bit (status bit 2). Writing 0x000 with bit 2 set clears the error bit.
- R11: Writing 0x000 with bit 0 set empties the receive buffer. Bit 1 set empties the transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| flash_sclk | output | 1 | Serial clock, idle low |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that software never lets a write instruction run past the data already pushed into the transmit buffer. They also assume that the flash changes `flash_miso` only after a falling clock edge. The stimulus keeps to both: every program sequence is preceded by pushes of exactly the bytes it sends. The bench's flash model also advances its output bit only on the falling edge of `flash_sclk`, counting from the moment chip select is released.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [5:0] {
        OP_STOP  = 6'd0,
        OP_CMD   = 6'd1,
        OP_ADDR  = 6'd2,
        OP_DUMMY = 6'd3,
        OP_READ  = 6'd4,
        OP_WRITE = 6'd5
    } op_e;

    localparam logic [11:0] A_CTRL  = 12'h000;
    localparam logic [11:0] A_STAT  = 12'h004;
    localparam logic [11:0] A_FADDR = 12'h008;
    localparam logic [11:0] A_TRIG  = 12'h00C;
    localparam logic [11:0] A_TXD   = 12'h010;
    localparam logic [11:0] A_KEY   = 12'h014;
    localparam logic [11:0] A_LOCK  = 12'h018;
    localparam logic [3:0]  WIN_RX  = 4'h1;
    localparam logic [3:0]  WIN_LUT = 4'h2;

    localparam logic [31:0] LOCK_KEY   = 32'h5AF0_0FA5;
    localparam logic [31:0] CMD_UNLOCK = 32'd1;
    localparam logic [31:0] CMD_LOCK   = 32'd2;
endpackage

// File: rtl/lfs_lut.sv
module lfs_lut import lfs_pkg::*; #(
    parameter int NWORDS = 32,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_wr_i,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [31:0]   wdata_i,
    input  logic          key_wr_i,
    input  logic          lock_wr_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [31:0]   rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [31:0]   rdata_b_o,
    output logic          locked_o,
    output logic          reject_o
);
    logic [31:0] mem [NWORDS];
    logic        key_ok_q, locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_ok_q <= 1'b0;
            locked_q <= 1'b1;
        end else if (any_wr_i) begin
            key_ok_q <= key_wr_i && (wdata_i == LOCK_KEY);
            if (lock_wr_i && key_ok_q) begin
                if (wdata_i == CMD_UNLOCK)    locked_q <= 1'b0;
                else if (wdata_i == CMD_LOCK) locked_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (wr_i && !locked_q) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
    assign locked_o  = locked_q;
    assign reject_o  = wr_i && locked_q;

    // R2: the table only opens right after a valid key write
    a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_q) |-> $past(key_ok_q));
endmodule

// File: rtl/lfs_bufs.sv
module lfs_bufs #(
    parameter int RXB = 128,
    parameter int TXB = 64,
    localparam int RXA  = $clog2(RXB),
    localparam int RXC  = RXA + 1,
    localparam int RXWA = RXA - 2,
    localparam int TXA  = $clog2(TXB),
    localparam int TXC  = TXA + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_flush_i,
    input  logic            rx_push_i,
    input  logic [7:0]      rx_byte_i,
    input  logic [RXWA-1:0] rx_widx_i,
    output logic [31:0]     rx_word_o,
    output logic [RXC-1:0]  rx_cnt_o,
    input  logic            tx_flush_i,
    input  logic            tx_push_i,
    input  logic [31:0]     tx_word_i,
    input  logic            tx_pop_i,
    output logic [7:0]      tx_byte_o
);
    logic [7:0]     rx_mem [RXB];
    logic [7:0]     tx_mem [TXB];
    logic [RXC-1:0] rx_cnt;
    logic [TXC-1:0] tx_cnt;
    logic [TXA-1:0] wp, rp;
    logic           rx_ok, tx_in_ok, tx_out_ok;

    assign rx_ok     = rx_push_i && (rx_cnt < RXC'(RXB));
    assign tx_in_ok  = tx_push_i && (tx_cnt <= TXC'(TXB - 4));
    assign tx_out_ok = tx_pop_i && (tx_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_cnt <= '0;
            tx_cnt <= '0;
            wp     <= '0;
            rp     <= '0;
        end else begin
            if (rx_flush_i) rx_cnt <= '0;
            else if (rx_ok) rx_cnt <= rx_cnt + 1'b1;
            if (tx_flush_i) begin
                tx_cnt <= '0;
                wp     <= '0;
                rp     <= '0;
            end else begin
                tx_cnt <= tx_cnt + (tx_in_ok ? TXC'(4) : '0) - (tx_out_ok ? TXC'(1) : '0);
                if (tx_in_ok)  wp <= wp + TXA'(4);
                if (tx_out_ok) rp <= rp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rx_ok && !rx_flush_i) rx_mem[rx_cnt[RXA-1:0]] <= rx_byte_i;
        if (tx_in_ok && !tx_flush_i) begin
            for (int k = 0; k < 4; k++) tx_mem[wp + TXA'(k)] <= tx_word_i[8*k +: 8];
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++) rx_word_o[8*k +: 8] = rx_mem[{rx_widx_i, 2'(k)}];
    end

    assign rx_cnt_o  = rx_cnt;
    assign tx_byte_o = tx_mem[rp];

    // R7: a full receive buffer keeps its count when more bytes arrive
    a_r7_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == RXC'(RXB)) && rx_push_i && !rx_flush_i |=> rx_cnt == RXC'(RXB));
    // R8: the engine never draws from an empty transmit buffer
    a_r8_tx_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_i |-> tx_cnt != '0);
endmodule

// File: rtl/lfs_engine.sv
module lfs_engine import lfs_pkg::*; #(
    parameter int HALF_DIV = 2,
    parameter int NWORDS   = 32,
    parameter int RXB      = 128,
    parameter int TXB      = 64,
    localparam int AW = $clog2(NWORDS),
    localparam int SW = AW - 2,
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] seq_i,
    input  logic [7:0]    size_i,
    input  logic [31:0]   faddr_i,
    output logic [AW-1:0] lut_addr_o,
    input  logic [31:0]   lut_word_i,
    input  logic [7:0]    tx_byte_i,
    output logic          tx_pop_o,
    output logic          rx_push_o,
    output logic [7:0]    rx_byte_o,
    output logic          sclk_o,
    output logic          cs_n_o,
    output logic          mosi_o,
    input  logic          miso_i,
    output logic          busy_o
);
    typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_LOW, S_HIGH, S_HOLD} st_e;

    st_e           st_q;
    logic [3:0]    pc_q;
    logic [SW-1:0] seq_q;
    logic [7:0]    size_q, bits_q, bytes_q, rxs_q;
    logic [31:0]   faddr_q, sh_q;
    logic [5:0]    op_q;
    logic [DW-1:0] div_q;

    logic [15:0] ins;
    logic [5:0]  op_n;
    logic [7:0]  oper, nbytes;
    logic        ld_end, ld_skip, edge_w, last_bit, more;
    logic        unused_pad;

    assign lut_addr_o = {seq_q, pc_q[2:1]};

    always_comb begin
        ins    = pc_q[0] ? lut_word_i[31:16] : lut_word_i[15:0];
        op_n   = ins[15:10];
        oper   = ins[7:0];
        nbytes = (size_q != 8'd0) ? size_q : oper;
        if (op_n == OP_READ && nbytes > 8'(RXB))  nbytes = 8'(RXB);
        if (op_n == OP_WRITE && nbytes > 8'(TXB)) nbytes = 8'(TXB);
        ld_end  = pc_q[3] || (op_n == OP_STOP) || (op_n > OP_WRITE);
        ld_skip = ((op_n == OP_READ || op_n == OP_WRITE) && nbytes == 8'd0)
                  || (op_n == OP_DUMMY && oper == 8'd0);
    end
    assign unused_pad = ^ins[9:8];

    assign edge_w   = (div_q == DW'(HALF_DIV - 1));
    assign last_bit = (bits_q == 8'd1);
    assign more     = (bytes_q > 8'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE; pc_q <= '0; seq_q <= '0; size_q <= '0; faddr_q <= '0;
            sh_q <= '0; rxs_q <= '0; bits_q <= '0; bytes_q <= '0; op_q <= '0; div_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start_i) begin
                    st_q <= S_SETUP; seq_q <= seq_i; size_q <= size_i;
                    faddr_q <= faddr_i; pc_q <= '0;
                end
                S_SETUP: st_q <= S_LOAD;
                S_LOAD: begin
                    if (ld_end) st_q <= S_HOLD;
                    else if (ld_skip) pc_q <= pc_q + 1'b1;
                    else begin
                        op_q <= op_n; div_q <= '0; st_q <= S_LOW;
                        bytes_q <= 8'd1; bits_q <= 8'd8; sh_q <= '0;
                        if (op_n == OP_CMD) sh_q <= {oper, 24'h0};
                        else if (op_n == OP_ADDR) begin
                            if (oper == 8'd32) begin sh_q <= faddr_q; bits_q <= 8'd32; end
                            else begin sh_q <= {faddr_q[23:0], 8'h0}; bits_q <= 8'd24; end
                        end
                        else if (op_n == OP_DUMMY) bits_q <= oper;
                        else begin
                            bytes_q <= nbytes;
                            if (op_n == OP_WRITE) sh_q <= {tx_byte_i, 24'h0};
                        end
                    end
                end
                S_LOW: if (edge_w) begin
                    div_q <= '0; st_q <= S_HIGH; rxs_q <= {rxs_q[6:0], miso_i};
                end else div_q <= div_q + 1'b1;
                S_HIGH: if (edge_w) begin
                    div_q <= '0;
                    sh_q  <= {sh_q[30:0], 1'b0};
                    if (!last_bit) begin
                        bits_q <= bits_q - 1'b1; st_q <= S_LOW;
                    end else if (more) begin
                        bits_q <= 8'd8; bytes_q <= bytes_q - 1'b1; st_q <= S_LOW;
                        if (op_q == OP_WRITE) sh_q <= {tx_byte_i, 24'h0};
                    end else begin
                        pc_q <= pc_q + 1'b1; st_q <= S_LOAD;
                    end
                end else div_q <= div_q + 1'b1;
                S_HOLD: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o    = (st_q != S_IDLE);
        cs_n_o    = (st_q == S_IDLE);
        sclk_o    = (st_q == S_HIGH);
        mosi_o    = sh_q[31] && (st_q == S_LOW || st_q == S_HIGH);
        rx_byte_o = rxs_q;
        rx_push_o = (st_q == S_HIGH) && edge_w && (op_q == OP_READ) && last_bit;
        tx_pop_o  = ((st_q == S_LOAD) && !ld_end && !ld_skip && (op_n == OP_WRITE))
                 || ((st_q == S_HIGH) && edge_w && (op_q == OP_WRITE) && last_bit && more);
    end

    // R4: data line holds steady across the high clock phase
    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o && $past(sclk_o) |-> $stable(mosi_o));
    // R9: busy only starts after an accepted trigger
    a_r9_busy_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/lutflash_seq.sv
module lutflash_seq import lfs_pkg::*; #(
    parameter int SEQS     = 8,
    parameter int RX_BYTES = 128,
    parameter int TX_BYTES = 64,
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        flash_sclk,
    output logic        flash_cs_n,
    output logic        flash_mosi,
    input  logic        flash_miso
);
    localparam int NWORDS = SEQS * 4;
    localparam int LAW    = $clog2(NWORDS);
    localparam int SW     = LAW - 2;
    localparam int RXC    = $clog2(RX_BYTES) + 1;
    localparam int RXWA   = $clog2(RX_BYTES) - 2;

    logic        in_lut, in_rx, is_ctrl, trig, start, busy, err_q, locked, reject;
    logic        tx_pop, rx_push;
    logic [7:0]  rx_byte, tx_byte;
    logic [31:0] faddr_q, lut_rd_a, lut_rd_b, rx_word;
    logic [LAW-1:0] lut_eng_addr;
    logic [RXC-1:0] rx_cnt;

    assign in_lut  = (reg_addr[11:8] == WIN_LUT);
    assign in_rx   = (reg_addr[11:8] == WIN_RX);
    assign is_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign trig    = reg_wr && (reg_addr == A_TRIG);
    assign start   = trig && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faddr_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_FADDR) faddr_q <= reg_wdata;
            if (is_ctrl && reg_wdata[2]) err_q <= 1'b0;
            if (reject || (trig && busy)) err_q <= 1'b1;
        end
    end

    lfs_lut #(.NWORDS(NWORDS)) u_lut (
        .clk(clk), .rst_n(rst_n), .any_wr_i(reg_wr),
        .wr_i(reg_wr && in_lut), .waddr_i(reg_addr[LAW+1:2]), .wdata_i(reg_wdata),
        .key_wr_i(reg_addr == A_KEY), .lock_wr_i(reg_addr == A_LOCK),
        .raddr_a_i(reg_addr[LAW+1:2]), .rdata_a_o(lut_rd_a),
        .raddr_b_i(lut_eng_addr), .rdata_b_o(lut_rd_b),
        .locked_o(locked), .reject_o(reject)
    );

    lfs_bufs #(.RXB(RX_BYTES), .TXB(TX_BYTES)) u_bufs (
        .clk(clk), .rst_n(rst_n),
        .rx_flush_i(is_ctrl && reg_wdata[0]), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
        .rx_widx_i(reg_addr[RXWA+1:2]), .rx_word_o(rx_word), .rx_cnt_o(rx_cnt),
        .tx_flush_i(is_ctrl && reg_wdata[1]), .tx_push_i(reg_wr && reg_addr == A_TXD),
        .tx_word_i(reg_wdata), .tx_pop_i(tx_pop), .tx_byte_o(tx_byte)
    );

    lfs_engine #(.HALF_DIV(HALF_DIV), .NWORDS(NWORDS), .RXB(RX_BYTES), .TXB(TX_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .seq_i(reg_wdata[8 +: SW]), .size_i(reg_wdata[7:0]), .faddr_i(faddr_q),
        .lut_addr_o(lut_eng_addr), .lut_word_i(lut_rd_b),
        .tx_byte_i(tx_byte), .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_byte_o(rx_byte),
        .sclk_o(flash_sclk), .cs_n_o(flash_cs_n), .mosi_o(flash_mosi),
        .miso_i(flash_miso), .busy_o(busy)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_lut)                      reg_rdata = lut_rd_a;
        else if (in_rx)                  reg_rdata = rx_word;
        else if (reg_addr == A_STAT)     reg_rdata = {16'h0, 8'(rx_cnt), 4'h0, locked, err_q, rx_cnt != '0, busy};
        else if (reg_addr == A_FADDR)    reg_rdata = faddr_q;
    end

    // R10: the error flag only drops on an explicit clear
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !(is_ctrl && reg_wdata[2]) |=> err_q);
endmodule

// File: tb/test_lutflash_seq.sv
module test_lutflash_seq;
    localparam logic [11:0] R_CTRL = 12'h000, R_STAT = 12'h004, R_ADDR = 12'h008,
                            R_TRIG = 12'h00C, R_TXD = 12'h010, R_KEY = 12'h014, R_LCK = 12'h018;
    localparam logic [31:0] KEYV = 32'h5AF0_0FA5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, cs_n, mosi, miso;
    int          checks = 0, fails = 0;
    logic [7:0]  exp_q[$];

    lutflash_seq i_lutflash_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_sclk(sclk),
        .flash_cs_n(cs_n), .flash_mosi(mosi), .flash_miso(miso)
    );

    function automatic logic [7:0] pat(int k);
        return 8'(8'h35 + k * 29);
    endfunction
    function automatic logic [15:0] ins(logic [5:0] op, logic [7:0] oper);
        return {op, 2'b00, oper};
    endfunction
    function automatic logic [31:0] pword(int b);
        return {pat(b + 3), pat(b + 2), pat(b + 1), pat(b)};
    endfunction

    // flash model: next bit after every falling clock edge
    int         bc;
    logic [7:0] pb;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) bc <= 0;
        else      bc <= bc + 1;
    end
    always_comb begin
        pb   = pat(bc >>> 3);
        miso = pb[3'd7 - 3'(bc)];
    end

    // scoreboard monitor on the outgoing line
    logic [7:0] mb = '0, me;
    int         mn = 0;
    always @(posedge sclk) begin
        if (!cs_n) begin
            mb = {mb[6:0], mosi};
            mn++;
            if (mn == 8) begin
                mn = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R4 R5 R6 R8 mosi byte actual=%02h expected=none", mb);
                end else begin
                    me = exp_q.pop_front();
                    if (me !== mb) begin
                        fails++;
                        $display("FAIL R4 R5 R6 R8 mosi byte actual=%02h expected=%02h", mb, me);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", r, act, exp);
        end
    endtask
    task automatic rchk(input string r, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(r, d, exp);
    endtask
    task automatic wait_idle;
        logic [31:0] s;
        do rd(R_STAT, s); while (s[0]);
    endtask
    task automatic push_exp(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=busy expected=idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rchk("R1 status after reset", R_STAT, 32'h8);
        chk("R1 cs_n idle", {31'h0, cs_n}, 32'h1);
        chk("R1 sclk idle", {31'h0, sclk}, 32'h0);

        wr(12'h204, 32'hDEAD_BEEF);
        rchk("R2 locked write ignored", 12'h204, 32'h0);
        rchk("R10 error on locked write", R_STAT, 32'hC);
        wr(R_CTRL, 32'h4);
        rchk("R10 error cleared", R_STAT, 32'h8);

        wr(R_KEY, KEYV); wr(R_ADDR, 32'h0); wr(R_LCK, 32'h1);
        rchk("R2 interrupted key stays locked", R_STAT, 32'h8);
        wr(R_KEY, KEYV); wr(R_LCK, 32'h1);
        rchk("R2 unlocked", R_STAT, 32'h0);

        wr(12'h210, {ins(6'd0, 8'h00), ins(6'd1, 8'h06)});
        wr(12'h220, {ins(6'd2, 8'd24), ins(6'd1, 8'h0B)});
        wr(12'h224, {ins(6'd4, 8'd16), ins(6'd3, 8'd8)});
        wr(12'h230, {ins(6'd2, 8'd32), ins(6'd1, 8'h0C)});
        wr(12'h234, {16'h0, ins(6'd4, 8'd4)});
        wr(12'h240, {ins(6'd2, 8'd24), ins(6'd1, 8'h02)});
        wr(12'h244, {16'h0, ins(6'd5, 8'd8)});
        wr(12'h250, {ins(6'd4, 8'd4), ins(6'd1, 8'h9F)});
        rchk("R3 table readback", 12'h224, {ins(6'd4, 8'd16), ins(6'd3, 8'd8)});

        wr(R_KEY, KEYV); wr(R_LCK, 32'h2);
        wr(12'h210, 32'h0);
        rchk("R2 relocked write ignored", 12'h210, {16'h0, ins(6'd1, 8'h06)});
        rchk("R2 relock status", R_STAT, 32'hC);
        wr(R_CTRL, 32'h4);

        push_exp(8'h06, 1);
        wr(R_TRIG, {20'h0, 4'd1, 8'd0});
        rd(R_STAT, d);
        chk("R9 busy after trigger", {31'h0, d[0]}, 32'h1);
        chk("R9 cs low while busy", {31'h0, cs_n}, 32'h0);
        wr(R_TRIG, {20'h0, 4'd1, 8'd0});
        wait_idle();
        rchk("R10 trigger while busy flagged", R_STAT, 32'hC);
        chk("R9 cs released at idle", {31'h0, cs_n}, 32'h1);
        wr(R_CTRL, 32'h4);

        wr(R_CTRL, 32'h1);
        wr(R_ADDR, 32'h0012_3456);
        push_exp(8'h0B, 1); push_exp(8'h12, 1); push_exp(8'h34, 1); push_exp(8'h56, 1);
        push_exp(8'h00, 17);
        wr(R_TRIG, {20'h0, 4'd2, 8'd0});
        wait_idle();
        rchk("R7 count after 16 byte read", R_STAT, 32'h0000_100A);
        for (int i = 0; i < 4; i++) rchk("R7 R6 read data word", 12'h100 + 12'(4 * i), pword(5 + 4 * i));

        wr(R_CTRL, 32'h1);
        wr(R_ADDR, 32'hA1B2_C3D4);
        push_exp(8'h0C, 1); push_exp(8'hA1, 1); push_exp(8'hB2, 1); push_exp(8'hC3, 1);
        push_exp(8'hD4, 1); push_exp(8'h00, 4);
        wr(R_TRIG, {20'h0, 4'd3, 8'd0});
        wait_idle();
        rchk("R5 wide address read word", 12'h100, pword(5));

        wr(R_TXD, 32'hFFFF_FFFF);
        wr(R_CTRL, 32'h2);
        wr(R_TXD, 32'h4433_2211);
        wr(R_TXD, 32'h8877_6655);
        wr(R_ADDR, 32'h0000_ABCD);
        push_exp(8'h02, 1); push_exp(8'h00, 1); push_exp(8'hAB, 1); push_exp(8'hCD, 1);
        for (int i = 1; i <= 8; i++) push_exp(8'(8'h11 * i), 1);
        wr(R_TRIG, {20'h0, 4'd4, 8'd0});
        wait_idle();
        rchk("R8 program leaves receive count", R_STAT, 32'h0000_040A);

        wr(R_CTRL, 32'h1);
        push_exp(8'h9F, 1); push_exp(8'h00, 12);
        wr(R_TRIG, {20'h0, 4'd5, 8'd12});
        wait_idle();
        rchk("R9 size override count", R_STAT, 32'h0000_0C0A);
        for (int i = 0; i < 3; i++) rchk("R9 size override data", 12'h100 + 12'(4 * i), pword(1 + 4 * i));

        wr(R_CTRL, 32'h1);
        rchk("R11 receive flush", R_STAT, 32'h8);

        push_exp(8'h9F, 1); push_exp(8'h00, 128);
        wr(R_TRIG, {20'h0, 4'd5, 8'd200});
        wait_idle();
        rchk("R7 clamp to 128 bytes", R_STAT, 32'h0000_800A);
        rchk("R7 last buffer word", 12'h17C, pword(125));

        chk("R4 all expected bytes seen", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule